// File: doc/BRIEF.md
# Two-Wire Bus Master Transfer Sequencer

This block runs a complete master transaction on a byte-oriented two-wire bus from a handful of CPU-visible registers. Software loads a target address and a byte count, then writes the control register with the enable, master and start bits set. The sequencer hands a start-plus-address command to a byte-level engine. It then streams bytes between a small data buffer and the engine until the count is used up, and closes the transfer in one of two ways. With the stop bit set it issues a stop and reloads the count. Without it, it raises an access-ready flag and leaves master mode, so software can follow with a repeated start.

The byte engine is driven through a single-outstanding command handshake. The command is one of start, send, receive or stop. The engine answers with a one-cycle done pulse that carries the acknowledge bit and, for a receive, the byte it read. The sequencer waits while the buffer cannot serve the next byte: when it is empty during a transmit, or full during a receive. It picks up again as soon as the CPU writes or reads the data register. A NACK, on the address or on a data byte, ends the transfer and is reported in status.

Top module: `twi_xfer_seq`

## Requirements
- R1: After reset the control, status, target and count registers read 0 and no command is presented to the engine.
- R2: Register addresses are 0 control, 1 status, 2 target address, 3 count, 4 data. Control writes keep only the bits set in 0xCF87, and the target address keeps its low 10 bits. Writing control with bit 15 (enable) clear returns every register to its reset value.
- R3: Writing control with bits 15, 10 (master) and 0 (start) set and bit 8 clear issues a start command (op 0) carrying the low 7 target address bits. The direction flag is set (read) when control bit 9 (transmit) is clear. Control bit 0 then reads back 0.
- R4: A start request with bit 10 clear (slave) or with bit 8 set (10-bit addressing) issues no command.
- R5: A NACK on the start command sets status bit 0, clears control bit 1 (stop) and issues no further command.
- R6: In transmit, each send command (op 1) carries the next buffered byte in write order, and the count register reads back the bytes still to be moved.
- R7: In transmit, no send is issued while the buffer is empty and bytes remain. Status bit 3 (transmit-ready) reads 1 in that state, and the transfer resumes after a data write.
- R8: In receive, one receive command (op 2) is issued per remaining byte. Received bytes are buffered up to the buffer depth, and the sequencer waits while the buffer is full. Status bit 2 reads 1 while the buffer holds bytes, and data reads return the bytes in arrival order.
- R9: When the count runs out with control bit 1 set, a stop command (op 3) is issued, control bit 1 is cleared and the count readback returns the count register value.
- R10: When the count runs out with control bit 1 clear, status bit 1 (access-ready) is set, control bit 10 is cleared and no stop command is issued.
- R11: A NACK on a sent byte sets status bit 0, clears control bit 1 and ends the transfer without a stop.
- R12: Writing 1 to status bit 0 or bit 1 clears that flag.
- R13: A command stays valid with unchanged op, address and byte until the engine signals done. Status bit 4 reads 1 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the buffer on the data address) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on reg_addr_i |
| cmd_valid_o | output | 1 | Command presented to the byte engine |
| cmd_op_o | output | 2 | Command: 0 start, 1 send, 2 receive, 3 stop |
| cmd_addr_o | output | BUS_AW | Target address for a start command |
| cmd_rnw_o | output | 1 | Direction for a start command, 1 for read |
| cmd_byte_o | output | 8 | Byte to send |
| eng_done_i | input | 1 | Engine finished the current command (one-cycle pulse) |
| eng_ack_i | input | 1 | Acknowledge received, valid with eng_done_i |
| eng_rx_byte_i | input | 8 | Byte received, valid with eng_done_i |

## Verification
On every cycle the assertions hold the command stable until the engine completes it. They also check that the buffer is never pushed when full or popped when empty, that the remaining count steps down by exactly one per moved byte and reloads after a stop, and that a rising NACK or access-ready flag comes with the stop or master bit already cleared. Only the directed scenarios can show the byte order on the wire and out of the data register. The same holds for the stalls at an empty or full buffer, the choice between a stop and access-ready at the end of the count, and the fact that a refused start request leaves the engine idle.

// File: rtl/twi_seq_pkg.sv
package twi_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } twi_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_NEXT,
    S_BYTE,
    S_STOP
  } seq_state_e;

  localparam int REG_W    = 16;
  localparam int CTRL_EN  = 15;
  localparam int CTRL_MST = 10;
  localparam int CTRL_TX  = 9;
  localparam int CTRL_TEN = 8;
  localparam int CTRL_STP = 1;
  localparam int CTRL_STT = 0;
  localparam logic [REG_W-1:0] CTRL_WMASK = 16'hCF87;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_TADDR = 3'd2;
  localparam logic [2:0] RA_COUNT = 3'd3;
  localparam logic [2:0] RA_DATA  = 3'd4;
endpackage

// File: rtl/twi_seq_buf.sv
module twi_seq_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] level;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (level == '0);
  assign full_o  = (level == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= wdata_i;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> !full_o);
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i) |-> !empty_o);
endmodule

// File: rtl/twi_seq_fsm.sv
module twi_seq_fsm
  import twi_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BUS_AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              go_i,
  input  logic              go_tx_i,
  input  logic              stop_req_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BUS_AW-1:0] taddr_i,
  input  logic              buf_empty_i,
  input  logic              buf_full_i,
  input  logic [7:0]        buf_head_i,
  output logic              buf_pop_o,
  output logic              buf_push_o,
  output logic [7:0]        buf_wdata_o,
  output logic              cmd_valid_o,
  output twi_op_e           cmd_op_o,
  output logic [BUS_AW-1:0] cmd_addr_o,
  output logic              cmd_rnw_o,
  output logic [7:0]        cmd_byte_o,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic [7:0]        rx_byte_i,
  output logic [CNT_W-1:0]  remaining_o,
  output logic              busy_o,
  output logic              rx_mode_o,
  output logic              tx_ready_o,
  output logic              nack_o,
  output logic              ardy_o,
  output logic              stop_clr_o,
  output logic              mst_clr_o
);
  seq_state_e        state_q;
  logic              dir_tx_q;
  logic [CNT_W-1:0]  remaining_q;
  logic [7:0]        byte_q;
  logic [BUS_AW-1:0] addr_q;
  logic              act, cnt_zero;

  assign act      = !clear_i;
  assign cnt_zero = (remaining_q == '0);

  assign cmd_valid_o = (state_q == S_ADDR) || (state_q == S_BYTE) || (state_q == S_STOP);
  assign cmd_addr_o  = addr_q;
  assign cmd_rnw_o   = !dir_tx_q;
  assign cmd_byte_o  = byte_q;
  assign remaining_o = remaining_q;
  assign busy_o      = (state_q != S_IDLE);
  assign rx_mode_o   = busy_o && !dir_tx_q;
  assign tx_ready_o  = busy_o && (state_q != S_ADDR) && dir_tx_q && !cnt_zero && !buf_full_i;

  always_comb begin
    case (state_q)
      S_BYTE:  cmd_op_o = dir_tx_q ? OP_SEND : OP_RECV;
      S_STOP:  cmd_op_o = OP_STOP;
      default: cmd_op_o = OP_START;
    endcase
  end

  assign nack_o      = act && done_i && !ack_i &&
                       ((state_q == S_ADDR) || (state_q == S_BYTE && dir_tx_q));
  assign stop_clr_o  = nack_o || (act && done_i && state_q == S_STOP);
  assign ardy_o      = act && (state_q == S_NEXT) && cnt_zero && !stop_req_i;
  assign mst_clr_o   = ardy_o;
  assign buf_pop_o   = act && (state_q == S_NEXT) && !cnt_zero && dir_tx_q && !buf_empty_i;
  assign buf_push_o  = act && (state_q == S_BYTE) && done_i && !dir_tx_q;
  assign buf_wdata_o = rx_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      dir_tx_q    <= 1'b0;
      remaining_q <= '0;
      byte_q      <= '0;
      addr_q      <= '0;
    end else if (clear_i) begin
      state_q     <= S_IDLE;
      remaining_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (go_i) begin
          state_q  <= S_ADDR;
          dir_tx_q <= go_tx_i;
          addr_q   <= taddr_i;
        end
        S_ADDR: if (done_i) begin
          if (!ack_i) state_q <= S_IDLE;
          else begin
            remaining_q <= count_i;
            state_q     <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (cnt_zero) state_q <= stop_req_i ? S_STOP : S_IDLE;
          else if (dir_tx_q) begin
            if (!buf_empty_i) begin
              byte_q  <= buf_head_i;
              state_q <= S_BYTE;
            end
          end else if (!buf_full_i) state_q <= S_BYTE;
        end
        S_BYTE: if (done_i) begin
          remaining_q <= remaining_q - CNT_W'(1);
          state_q     <= (dir_tx_q && !ack_i) ? S_IDLE : S_NEXT;
        end
        S_STOP: if (done_i) begin
          remaining_q <= count_i;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // one byte per completed data command
  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BYTE && done_i && !clear_i) |=> (remaining_q == $past(remaining_q) - CNT_W'(1)));
  a_r9_count_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STOP && done_i && !clear_i) |=> (remaining_q == $past(count_i)));
endmodule

// File: rtl/twi_xfer_seq.sv
module twi_xfer_seq
  import twi_seq_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int CNT_W   = 16,
  parameter int TADDR_W = 10,
  parameter int BUS_AW  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [BUS_AW-1:0] cmd_addr_o,
  output logic              cmd_rnw_o,
  output logic [7:0]        cmd_byte_o,
  input  logic              eng_done_i,
  input  logic              eng_ack_i,
  input  logic [7:0]        eng_rx_byte_i
);
  logic [REG_W-1:0]   ctrl_q;
  logic [TADDR_W-1:0] taddr_q;
  logic [CNT_W-1:0]   count_q;
  logic               stat_nack_q, stat_ardy_q;

  logic wr_ctrl, wr_stat, soft_clear, go;
  logic fsm_busy, rx_mode, tx_ready, nack_p, ardy_p, stop_clr, mst_clr;
  logic buf_empty, buf_full, buf_push, buf_pop, fsm_push, fsm_pop, cpu_push, cpu_pop, flush;
  logic [7:0] buf_head, buf_wdata, fsm_wdata;
  logic [CNT_W-1:0] remaining;
  twi_op_e op;

  assign wr_ctrl    = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_stat    = reg_we_i && (reg_addr_i == RA_STAT);
  assign soft_clear = wr_ctrl && !reg_wdata_i[CTRL_EN];
  assign go         = wr_ctrl && reg_wdata_i[CTRL_EN] && reg_wdata_i[CTRL_MST] &&
                      !reg_wdata_i[CTRL_TEN] && reg_wdata_i[CTRL_STT] && !fsm_busy;
  assign flush      = soft_clear || go;

  assign cpu_push  = reg_we_i && (reg_addr_i == RA_DATA) && !rx_mode && !buf_full && !flush;
  assign cpu_pop   = reg_re_i && (reg_addr_i == RA_DATA) && !buf_empty && !fsm_pop && !flush;
  assign buf_push  = cpu_push || fsm_push;
  assign buf_pop   = cpu_pop || fsm_pop;
  assign buf_wdata = fsm_push ? fsm_wdata : reg_wdata_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      taddr_q     <= '0;
      count_q     <= '0;
      stat_nack_q <= 1'b0;
      stat_ardy_q <= 1'b0;
    end else if (soft_clear) begin
      ctrl_q      <= '0;
      taddr_q     <= '0;
      count_q     <= '0;
      stat_nack_q <= 1'b0;
      stat_ardy_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= reg_wdata_i & CTRL_WMASK;
        if (go) ctrl_q[CTRL_STT] <= 1'b0;
      end else begin
        if (stop_clr) ctrl_q[CTRL_STP] <= 1'b0;
        if (mst_clr)  ctrl_q[CTRL_MST] <= 1'b0;
      end
      if (reg_we_i && reg_addr_i == RA_TADDR) taddr_q <= reg_wdata_i[TADDR_W-1:0];
      if (reg_we_i && reg_addr_i == RA_COUNT) count_q <= reg_wdata_i[CNT_W-1:0];
      stat_nack_q <= (stat_nack_q && !(wr_stat && reg_wdata_i[0])) || nack_p;
      stat_ardy_q <= (stat_ardy_q && !(wr_stat && reg_wdata_i[1])) || ardy_p;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_CTRL:  reg_rdata_o = ctrl_q;
      RA_STAT:  reg_rdata_o = {11'b0, fsm_busy, tx_ready, !buf_empty, stat_ardy_q, stat_nack_q};
      RA_TADDR: reg_rdata_o = 16'(taddr_q);
      RA_COUNT: reg_rdata_o = 16'(remaining);
      RA_DATA:  reg_rdata_o = {8'b0, buf_head};
      default:  reg_rdata_o = '0;
    endcase
  end

  twi_seq_buf #(.W(8), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (buf_push),
    .wdata_i (buf_wdata),
    .pop_i   (buf_pop),
    .rdata_o (buf_head),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  twi_seq_fsm #(.CNT_W(CNT_W), .BUS_AW(BUS_AW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (soft_clear),
    .go_i        (go),
    .go_tx_i     (reg_wdata_i[CTRL_TX]),
    .stop_req_i  (ctrl_q[CTRL_STP]),
    .count_i     (count_q),
    .taddr_i     (taddr_q[BUS_AW-1:0]),
    .buf_empty_i (buf_empty),
    .buf_full_i  (buf_full),
    .buf_head_i  (buf_head),
    .buf_pop_o   (fsm_pop),
    .buf_push_o  (fsm_push),
    .buf_wdata_o (fsm_wdata),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (op),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_rnw_o   (cmd_rnw_o),
    .cmd_byte_o  (cmd_byte_o),
    .done_i      (eng_done_i),
    .ack_i       (eng_ack_i),
    .rx_byte_i   (eng_rx_byte_i),
    .remaining_o (remaining),
    .busy_o      (fsm_busy),
    .rx_mode_o   (rx_mode),
    .tx_ready_o  (tx_ready),
    .nack_o      (nack_p),
    .ardy_o      (ardy_p),
    .stop_clr_o  (stop_clr),
    .mst_clr_o   (mst_clr)
  );

  assign cmd_op_o = op;

  a_r13_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !eng_done_i && !soft_clear) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o) && $stable(cmd_byte_o)));
  a_r11_nack_drops_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_nack_q) |-> !ctrl_q[CTRL_STP]);
  a_r10_ardy_drops_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_ardy_q) |-> !ctrl_q[CTRL_MST]);
endmodule

// File: tb/twi_xfer_seq_test.sv
module twi_xfer_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        cmd_valid_o, cmd_rnw_o;
  logic [1:0]  cmd_op_o;
  logic [6:0]  cmd_addr_o;
  logic [7:0]  cmd_byte_o;
  logic        eng_done_i = 1'b0, eng_ack_i = 1'b0;
  logic [7:0]  eng_rx_byte_i = '0;

  int n_tests = 0, n_fail = 0;
  int n_log = 0, n_send = 0, n_recv = 0, nack_at = 0;
  bit addr_nack = 0, finished = 0;
  logic [1:0] op_log [16];
  logic [7:0] byte_log [16];
  logic [6:0] addr_log;
  logic       rnw_log;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  twi_xfer_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
    .cmd_rnw_o(cmd_rnw_o), .cmd_byte_o(cmd_byte_o), .eng_done_i(eng_done_i),
    .eng_ack_i(eng_ack_i), .eng_rx_byte_i(eng_rx_byte_i)
  );

  // byte engine model: answers each command at the negedge it is seen
  initial begin
    forever begin
      @(negedge clk_i);
      if (eng_done_i) eng_done_i = 1'b0;
      else if (cmd_valid_o && rst_ni) begin
        eng_ack_i = 1'b1;
        if (cmd_op_o == 2'd0) begin
          addr_log = cmd_addr_o;
          rnw_log  = cmd_rnw_o;
          eng_ack_i = !addr_nack;
        end else if (cmd_op_o == 2'd1) begin
          n_send++;
          eng_ack_i = (n_send != nack_at);
        end else if (cmd_op_o == 2'd2) begin
          eng_rx_byte_i = 8'hA0 + 8'(n_recv);
          n_recv++;
        end
        if (n_log < 16) begin
          op_log[n_log]   = cmd_op_o;
          byte_log[n_log] = cmd_byte_o;
        end
        n_log++;
        eng_done_i = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_re_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(3'd1, s);
      if (!s[4]) break;
    end
  endtask

  task automatic new_log();
    n_log = 0; n_send = 0; n_recv = 0; nack_at = 0; addr_nack = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 target", v, 0);
    rd(3'd3, v); chk("R1 count", v, 0);
    chk("R1 cmd_valid", cmd_valid_o, 0);
  endtask

  task automatic t_mask_and_refuse();
    logic [15:0] v;
    new_log();
    wr(3'd0, 16'hFBFE);
    rd(3'd0, v); chk("R2 ctrl mask", v, 16'hCB86);
    wr(3'd0, 16'h8401 | 16'h0100);
    repeat (8) @(negedge clk_i);
    chk("R4 no cmd on slave/10-bit", n_log, 0);
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); chk("R2 target mask", v, 16'h03FF);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'h0000);
    rd(3'd2, v); chk("R2 clear target", v, 0);
    rd(3'd3, v); chk("R2 clear count", v, 0);
    rd(3'd0, v); chk("R2 clear ctrl", v, 0);
  endtask

  task automatic t_addr_nack();
    logic [15:0] v;
    new_log(); addr_nack = 1;
    wr(3'd2, 16'h0055);
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h8603);
    repeat (10) @(negedge clk_i);
    chk("R5 one command", n_log, 1);
    chk("R3 start op", op_log[0], 0);
    chk("R3 address", addr_log, 7'h55);
    chk("R3 write dir", rnw_log, 0);
    rd(3'd1, v); chk("R5 nack flag", v & 16'h1F, 16'h1);
    rd(3'd0, v); chk("R5 stop cleared", v, 16'h8600);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); chk("R12 nack w1c", v, 0);
  endtask

  task automatic t_tx_stop();
    logic [15:0] v;
    new_log();
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h8603);
    repeat (10) @(negedge clk_i);
    chk("R7 stall on empty", n_log, 1);
    rd(3'd1, v); chk("R7 tx ready busy", v & 16'h18, 16'h18);
    rd(3'd0, v); chk("R3 start self-clear", v[0], 0);
    wr(3'd4, 16'h0011);
    repeat (10) @(negedge clk_i);
    chk("R7 resumes", n_log, 2);
    rd(3'd3, v); chk("R6 remaining", v, 2);
    wr(3'd4, 16'h0022);
    wr(3'd4, 16'h0033);
    wait_idle();
    chk("R6 command count", n_log, 5);
    chk("R6 op1", op_log[1], 1);
    chk("R6 byte1", byte_log[1], 8'h11);
    chk("R6 byte2", byte_log[2], 8'h22);
    chk("R6 byte3", byte_log[3], 8'h33);
    chk("R9 stop op", op_log[4], 3);
    rd(3'd0, v); chk("R9 stop bit cleared", v, 16'h8600);
    rd(3'd3, v); chk("R9 count reload", v, 3);
    rd(3'd1, v); chk("R9 no flags", v, 0);
  endtask

  task automatic t_rx_ardy();
    logic [15:0] v;
    new_log();
    wr(3'd3, 16'd6);
    wr(3'd0, 16'h8401);
    repeat (40) @(negedge clk_i);
    chk("R8 stall when full", n_log, 5);
    chk("R3 read dir", rnw_log, 1);
    chk("R8 recv op", op_log[1], 2);
    rd(3'd1, v); chk("R8 rx ready busy", v & 16'h14, 16'h14);
    rd(3'd3, v); chk("R8 remaining", v, 2);
    for (int i = 0; i < 4; i++) begin
      rd(3'd4, v); chk("R8 data order", v, 16'hA0 + i);
    end
    wait_idle();
    chk("R10 no stop", n_log, 7);
    for (int i = 4; i < 6; i++) begin
      rd(3'd4, v); chk("R8 data order tail", v, 16'hA0 + i);
    end
    rd(3'd1, v); chk("R10 access ready", v, 16'h2);
    rd(3'd0, v); chk("R10 master cleared", v, 16'h8000);
    wr(3'd1, 16'h0002);
    rd(3'd1, v); chk("R12 ardy w1c", v, 0);
  endtask

  task automatic t_data_nack();
    logic [15:0] v;
    new_log(); nack_at = 2;
    wr(3'd3, 16'd4);
    wr(3'd0, 16'h8603);
    wr(3'd4, 16'h00C1);
    wr(3'd4, 16'h00C2);
    wr(3'd4, 16'h00C3);
    wr(3'd4, 16'h00C4);
    wait_idle();
    chk("R11 sends stop at nack", n_log, 3);
    chk("R11 last op send", op_log[2], 1);
    rd(3'd1, v); chk("R11 nack flag", v[0], 1);
    rd(3'd0, v); chk("R11 stop cleared", v, 16'h8600);
    rd(3'd3, v); chk("R11 remaining", v, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_mask_and_refuse();
    t_addr_nack();
    t_tx_stop();
    t_rx_ardy();
    t_data_nack();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule